// File: doc/BRIEF.md
# Split-Datapath Four-Lane Shuffle and Logical Unit

This block executes 128-bit four-lane single-precision data-rearrangement instructions on a 64-bit datapath. It owns a small register model of `NREG` 128-bit registers, each kept as a low half (lanes 0 and 1) and a high half (lanes 2 and 3), plus one 128-bit temporary. An internal sequencer expands each accepted instruction into one to three 64-bit micro-operations, issues one per cycle, and writes each micro-operation's result into the register model and onto the result port one cycle after issue. While an instruction is still expanding, `in_ready` is low.

The general four-lane shuffle is the reason for the sequencer. It writes its destination in two halves, and the second half can still need the first half's original contents. The unit therefore first saves the destination into the temporary, then builds the low half from that copy and the high half from the source. The same datapath also handles interleave-low and interleave-high, register move, four bitwise operations, a 64-bit word shuffle, 16-bit word insert and 16-bit word extract. Loads of either half from `in_data` let a caller fill registers through the normal interface. A move to a spare register reads any register back.

Opcode values on `in_op`: 0 load-low, 1 load-high, 2 move, 3 and, 4 or, 5 xor, 6 and-not, 7 interleave-low, 8 interleave-high, 9 four-lane shuffle, 10 word shuffle, 11 word insert, 12 word extract. Codes 13 to 15 take one issue slot and produce nothing. Result kinds on `res_kind`: 0 low half written, 1 high half written, 2 temporary copy, 3 scalar result. Lane i of a register is bits 32i+31..32i, and word j is bits 16j+15..16j.

Top module: `shuf_unit`

## Requirements
- R1: After reset every register and the temporary read as zero, `res_valid` is 0 and `in_ready` is 1.
- R2: A four-lane shuffle (opcode 9) produces exactly three results, in consecutive cycles and in this order: kind 2 (the destination's original low half, saved with the whole register into the temporary), kind 0, then kind 1. `in_ready` stays low for the two cycles after acceptance.
- R3: After a four-lane shuffle, destination lanes 0 and 1 are original destination lanes imm[1:0] and imm[3:2], and lanes 2 and 3 are source lanes imm[5:4] and imm[7:6]. When source and destination are the same register, the source lanes are also taken from the original value.
- R4: Interleave-low (7) yields {s1,d1,s0,d0} with the high half written first, then the low half. Interleave-high (8) yields {s3,d3,s2,d2} with the low half written first, then the high half. Both are correct when source equals destination.
- R5: Move (2) copies the source. And (3), or (4), xor (5) and and-not (6, result ~dst & src) combine destination and source. Each of these writes the low half, then the high half.
- R6: Word insert (11) replaces only word imm[2:0] of the destination with in_data[15:0]. It is one micro-op, reporting the touched half (imm[2]).
- R7: Word extract (12) returns word imm[2:0] of the source zero-extended, as kind 3, and changes no register.
- R8: Word shuffle (10) sets destination word i (i = 0..3) to source low-half word imm[2i+1:2i] and leaves the destination high half unchanged.
- R9: Each micro-op's result appears exactly one cycle after it issues. Single-micro-op instructions are accepted on back-to-back cycles.
- R10: Load-low (0) and load-high (1) write in_data into the named half of the destination and leave the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| in_op | input | 4 | Opcode |
| in_dst | input | RW | Destination register index |
| in_src | input | RW | Source register index |
| in_imm | input | 8 | Lane/word select immediate |
| in_data | input | 64 | Load value or inserted word |
| res_valid | output | 1 | A micro-op result is present |
| res_kind | output | 2 | 0 low half, 1 high half, 2 temporary, 3 scalar |
| res_reg | output | RW | Destination index of the instruction |
| res_data | output | 64 | Result of the micro-op |

## Verification
The shuffle is tried with the identity select (0xE4), full reversal (0x1B), all-lane-zero (0x00) and all-lane-three (0xFF) immediates on distinct registers. These separate a swapped select field from a swapped operand and show whether each lane field is decoded. A half-swap immediate with source equal to destination shows whether the high half reads the saved copy or the already overwritten register. Interleaves are run both on distinct registers and with source equal to destination, which exposes a wrong half ordering. Word insert and extract are tried at positions in both halves, and back-to-back loads expose a lost issue slot or an extra latency cycle.

// File: rtl/shuf_pkg.sv
// Shared constants, opcode/kind encodings and lane helpers for the shuffle unit.
// Assumes four 32-bit lanes per 128-bit register, two lanes per 64-bit half.
package shuf_pkg;
    localparam int LANE_W = 32;
    localparam int HALF_W = 64;
    localparam int VEC_W  = 128;
    localparam int WORD_W = 16;
    localparam int IMM_W  = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD_LO = 4'd0,
        OP_LOAD_HI = 4'd1,
        OP_MOVE    = 4'd2,
        OP_AND     = 4'd3,
        OP_OR      = 4'd4,
        OP_XOR     = 4'd5,
        OP_ANDNOT  = 4'd6,
        OP_ILV_LO  = 4'd7,
        OP_ILV_HI  = 4'd8,
        OP_SHUF4   = 4'd9,
        OP_WSHUF   = 4'd10,
        OP_WINS    = 4'd11,
        OP_WEXT    = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        K_LO   = 2'd0,
        K_HI   = 2'd1,
        K_TMP  = 2'd2,
        K_SCAL = 2'd3
    } kind_e;

    // Number of 64-bit micro-ops an opcode expands into.
    function automatic logic [1:0] uop_count(input logic [OP_W-1:0] op);
        case (op)
            OP_MOVE, OP_AND, OP_OR, OP_XOR, OP_ANDNOT,
            OP_ILV_LO, OP_ILV_HI:  return 2'd2;
            OP_SHUF4:              return 2'd3;
            default:               return 2'd1;
        endcase
    endfunction

    // Select a 32-bit lane of a 128-bit value.
    function automatic logic [LANE_W-1:0] lane_of(input logic [VEC_W-1:0] v,
                                                  input logic [1:0] i);
        return v[{i, 5'd0} +: LANE_W];
    endfunction

    // Select a 16-bit word of a 128-bit value.
    function automatic logic [WORD_W-1:0] word_of(input logic [VEC_W-1:0] v,
                                                  input logic [2:0] i);
        return v[{i, 4'd0} +: WORD_W];
    endfunction
endpackage

// File: rtl/shuf_seq.sv
// Micro-op sequencer: accepts one instruction when idle and emits its micro-ops
// one per cycle. The first micro-op issues in the acceptance cycle; later ones
// come from a held copy. Assumes at most three micro-ops per instruction.
module shuf_seq
    import shuf_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [RW-1:0]     in_dst,
    input  logic [RW-1:0]     in_src,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [HALF_W-1:0] in_data,
    output logic              in_ready,
    output logic              u_valid,
    output logic [OP_W-1:0]   u_op,
    output logic [1:0]        u_step,
    output logic [RW-1:0]     u_dst,
    output logic [RW-1:0]     u_src,
    output logic [IMM_W-1:0]  u_imm,
    output logic [HALF_W-1:0] u_data
);
    logic              busy_q;
    logic [1:0]        step_q;
    logic [OP_W-1:0]   op_q;
    logic [RW-1:0]     dst_q;
    logic [RW-1:0]     src_q;
    logic [IMM_W-1:0]  imm_q;
    logic [HALF_W-1:0] data_q;

    // Pick the issuing micro-op: held instruction while busy, else the input.
    always_comb begin
        in_ready = !busy_q;
        if (busy_q) begin
            u_valid = 1'b1;
            u_op    = op_q;
            u_step  = step_q;
            u_dst   = dst_q;
            u_src   = src_q;
            u_imm   = imm_q;
            u_data  = data_q;
        end else begin
            u_valid = in_valid;
            u_op    = in_op;
            u_step  = 2'd0;
            u_dst   = in_dst;
            u_src   = in_src;
            u_imm   = in_imm;
            u_data  = in_data;
        end
    end

    // Hold multi-micro-op instructions and advance the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= 2'd0;
            op_q   <= '0;
            dst_q  <= '0;
            src_q  <= '0;
            imm_q  <= '0;
            data_q <= '0;
        end else if (busy_q) begin
            if (step_q == uop_count(op_q) - 2'd1) begin
                busy_q <= 1'b0;
                step_q <= 2'd0;
            end else begin
                step_q <= step_q + 2'd1;
            end
        end else if (in_valid && uop_count(in_op) > 2'd1) begin
            busy_q <= 1'b1;
            step_q <= 2'd1;
            op_q   <= in_op;
            dst_q  <= in_dst;
            src_q  <= in_src;
            imm_q  <= in_imm;
            data_q <= in_data;
        end
    end
endmodule

// File: rtl/shuf_regs.sv
// Register model: NREG 128-bit registers written one 64-bit half at a time,
// plus a 128-bit temporary. Two combinational read ports; writes land at the
// clock edge so the next micro-op reads the updated value.
module shuf_regs
    import shuf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int RW   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RW-1:0]     rd_a_idx,
    input  logic [RW-1:0]     rd_b_idx,
    output logic [VEC_W-1:0]  rd_a,
    output logic [VEC_W-1:0]  rd_b,
    output logic [VEC_W-1:0]  tmp_v,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_idx,
    input  logic              wr_half,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              tmp_we
);
    logic [VEC_W-1:0] rows [NREG];
    logic [VEC_W-1:0] tmp_q;

    for (genvar g = 0; g < NREG; g++) begin : g_row
        logic [VEC_W-1:0] q;
        // Write the selected half of this register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_idx == RW'(g)) begin
                if (wr_half) q[VEC_W-1:HALF_W] <= wr_data;
                else         q[HALF_W-1:0]     <= wr_data;
            end
        end
        assign rows[g] = q;
    end

    // Capture the whole destination register into the temporary.
    always_ff @(posedge clk) begin
        if (!rst_n)      tmp_q <= '0;
        else if (tmp_we) tmp_q <= rd_a;
    end

    assign rd_a  = rows[rd_a_idx];
    assign rd_b  = rows[rd_b_idx];
    assign tmp_v = tmp_q;
endmodule

// File: rtl/shuf_exec.sv
// Combinational 64-bit execute stage: given one micro-op and its operands,
// produces the half to write (or the temporary copy, or a scalar result).
// Assumes the step numbering produced by shuf_seq.
module shuf_exec
    import shuf_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic              valid,
    input  logic [OP_W-1:0]   op,
    input  logic [1:0]        step,
    input  logic [RW-1:0]     dst_idx,
    input  logic [RW-1:0]     src_idx,
    input  logic [IMM_W-1:0]  imm,
    input  logic [HALF_W-1:0] data,
    input  logic [VEC_W-1:0]  dst_v,
    input  logic [VEC_W-1:0]  src_v,
    input  logic [VEC_W-1:0]  tmp_v,
    output logic              reg_we,
    output logic              reg_half,
    output logic              tmp_we,
    output logic              res_en,
    output logic [1:0]        res_kind,
    output logic [HALF_W-1:0] res_data
);
    logic              same;
    logic [VEC_W-1:0]  shuf_src;
    logic [HALF_W-1:0] d_h, s_h, ins_base;
    logic              scal;

    // Operand selection shared by several operations.
    always_comb begin
        same     = (dst_idx == src_idx);
        shuf_src = same ? tmp_v : src_v;
        d_h      = step[0] ? dst_v[VEC_W-1:HALF_W] : dst_v[HALF_W-1:0];
        s_h      = step[0] ? src_v[VEC_W-1:HALF_W] : src_v[HALF_W-1:0];
        ins_base = imm[2] ? dst_v[VEC_W-1:HALF_W] : dst_v[HALF_W-1:0];
    end

    // Decode the micro-op into a write and its data.
    always_comb begin
        reg_we   = 1'b0;
        reg_half = 1'b0;
        tmp_we   = 1'b0;
        scal     = 1'b0;
        res_data = '0;
        case (op)
            OP_LOAD_LO: begin reg_we = 1'b1; res_data = data; end
            OP_LOAD_HI: begin reg_we = 1'b1; reg_half = 1'b1; res_data = data; end
            OP_MOVE:    begin reg_we = 1'b1; reg_half = step[0]; res_data = s_h; end
            OP_AND:     begin reg_we = 1'b1; reg_half = step[0]; res_data = d_h & s_h; end
            OP_OR:      begin reg_we = 1'b1; reg_half = step[0]; res_data = d_h | s_h; end
            OP_XOR:     begin reg_we = 1'b1; reg_half = step[0]; res_data = d_h ^ s_h; end
            OP_ANDNOT:  begin reg_we = 1'b1; reg_half = step[0]; res_data = ~d_h & s_h; end
            OP_ILV_LO: begin
                reg_we = 1'b1;
                if (step == 2'd0) begin
                    reg_half = 1'b1;
                    res_data = {lane_of(src_v, 2'd1), lane_of(dst_v, 2'd1)};
                end else begin
                    res_data = {lane_of(src_v, 2'd0), lane_of(dst_v, 2'd0)};
                end
            end
            OP_ILV_HI: begin
                reg_we = 1'b1;
                if (step == 2'd0) begin
                    res_data = {lane_of(src_v, 2'd2), lane_of(dst_v, 2'd2)};
                end else begin
                    reg_half = 1'b1;
                    res_data = {lane_of(src_v, 2'd3), lane_of(dst_v, 2'd3)};
                end
            end
            OP_SHUF4: begin
                if (step == 2'd0) begin
                    tmp_we   = 1'b1;
                    res_data = dst_v[HALF_W-1:0];
                end else if (step == 2'd1) begin
                    reg_we   = 1'b1;
                    res_data = {lane_of(tmp_v, imm[3:2]), lane_of(tmp_v, imm[1:0])};
                end else begin
                    reg_we   = 1'b1;
                    reg_half = 1'b1;
                    res_data = {lane_of(shuf_src, imm[7:6]), lane_of(shuf_src, imm[5:4])};
                end
            end
            OP_WSHUF: begin
                reg_we   = 1'b1;
                res_data = {word_of(src_v, {1'b0, imm[7:6]}), word_of(src_v, {1'b0, imm[5:4]}),
                            word_of(src_v, {1'b0, imm[3:2]}), word_of(src_v, {1'b0, imm[1:0]})};
            end
            OP_WINS: begin
                reg_we   = 1'b1;
                reg_half = imm[2];
                res_data = ins_base;
                res_data[{imm[1:0], 4'd0} +: WORD_W] = data[WORD_W-1:0];
            end
            OP_WEXT: begin
                scal     = 1'b1;
                res_data = {{(HALF_W-WORD_W){1'b0}}, word_of(src_v, imm[2:0])};
            end
            default: ;
        endcase
        reg_we   = reg_we & valid;
        tmp_we   = tmp_we & valid;
        scal     = scal & valid;
        res_en   = reg_we | tmp_we | scal;
        res_kind = scal ? K_SCAL : (tmp_we ? K_TMP : (reg_half ? K_HI : K_LO));
    end
endmodule

// File: rtl/shuf_unit.sv
// Top of the split-datapath shuffle unit: sequencer, register model and
// execute stage, with the micro-op result registered onto the result port.
// Assumes callers hold in_* steady while in_valid is high and in_ready is low.
module shuf_unit
    import shuf_pkg::*;
#(
    parameter  int NREG = 8,
    localparam int RW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OP_W-1:0]   in_op,
    input  logic [RW-1:0]     in_dst,
    input  logic [RW-1:0]     in_src,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [HALF_W-1:0] in_data,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [RW-1:0]     res_reg,
    output logic [HALF_W-1:0] res_data
);
    logic              u_valid;
    logic [OP_W-1:0]   u_op;
    logic [1:0]        u_step;
    logic [RW-1:0]     u_dst, u_src;
    logic [IMM_W-1:0]  u_imm;
    logic [HALF_W-1:0] u_data;
    logic [VEC_W-1:0]  dst_v, src_v, tmp_v;
    logic              reg_we, reg_half, tmp_we, x_en;
    logic [1:0]        x_kind;
    logic [HALF_W-1:0] x_data;

    shuf_seq #(.RW(RW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst), .in_src(in_src),
        .in_imm(in_imm), .in_data(in_data), .in_ready(in_ready),
        .u_valid(u_valid), .u_op(u_op), .u_step(u_step), .u_dst(u_dst),
        .u_src(u_src), .u_imm(u_imm), .u_data(u_data)
    );

    shuf_regs #(.NREG(NREG), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(u_dst), .rd_b_idx(u_src),
        .rd_a(dst_v), .rd_b(src_v), .tmp_v(tmp_v),
        .wr_en(reg_we), .wr_idx(u_dst), .wr_half(reg_half), .wr_data(x_data),
        .tmp_we(tmp_we)
    );

    shuf_exec #(.RW(RW)) u_exec (
        .valid(u_valid), .op(u_op), .step(u_step), .dst_idx(u_dst),
        .src_idx(u_src), .imm(u_imm), .data(u_data),
        .dst_v(dst_v), .src_v(src_v), .tmp_v(tmp_v),
        .reg_we(reg_we), .reg_half(reg_half), .tmp_we(tmp_we),
        .res_en(x_en), .res_kind(x_kind), .res_data(x_data)
    );

    // Register the micro-op result onto the output port (one-cycle latency).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_kind  <= 2'd0;
            res_reg   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= x_en;
            res_kind  <= x_kind;
            res_reg   <= u_dst;
            res_data  <= x_data;
        end
    end
endmodule

// File: rtl/shuf_unit_chk.sv
// Protocol checker for shuf_unit, bound to every instance of the top.
module shuf_unit_chk
    import shuf_pkg::*;
#(
    parameter int RW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [OP_W-1:0]   in_op,
    input logic              res_valid,
    input logic [1:0]        res_kind,
    input logic [RW-1:0]     res_reg,
    input logic [HALF_W-1:0] res_data
);
    logic acc;
    assign acc = in_valid && in_ready;

    // R2: temporary copy is followed by the low half, then the high half.
    a_r2_shuf_order: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == K_TMP) |=>
        (res_valid && res_kind == K_LO) ##1 (res_valid && res_kind == K_HI));

    // R2: accepting a four-lane shuffle blocks input for two cycles.
    a_r2_shuf_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == OP_SHUF4) |=> !in_ready ##1 !in_ready);

    // R9: every defined instruction yields a result one cycle after acceptance.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op <= OP_WEXT) |=> res_valid);

    // R6: word insert is a single micro-op, so input frees at once.
    a_r6_ins_single: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_op == OP_WINS) |=> in_ready);

    // R7: a scalar extract result is zero above bit 15.
    a_r7_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == K_SCAL) |-> res_data[HALF_W-1:WORD_W] == '0);

    // R1: no result register value escapes without a valid flag mid-reset.
    a_r1_reg_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown(res_reg));
endmodule

bind shuf_unit shuf_unit_chk #(.RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .res_valid(res_valid), .res_kind(res_kind),
    .res_reg(res_reg), .res_data(res_data)
);

// File: tb/tb_shuf_unit.sv
// Behavioural reference bench for shuf_unit: a lane-level model predicts each
// result and its cycle; a monitor compares on every falling edge.
module tb_shuf_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_op = '0;
    logic [2:0]  in_dst = '0, in_src = '0;
    logic [7:0]  in_imm = '0;
    logic [63:0] in_data = '0;
    logic        res_valid;
    logic [1:0]  res_kind;
    logic [2:0]  res_reg;
    logic [63:0] res_data;

    int checks = 0, failures = 0, cyc = 0, busy_until = 0;

    logic [127:0] mr [8];
    int           q_cyc [$];
    logic [1:0]   q_kind [$];
    int           q_reg [$];
    logic [63:0]  q_data [$];
    string        q_tag [$];

    shuf_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
        .in_data(in_data), .res_valid(res_valid), .res_kind(res_kind),
        .res_reg(res_reg), .res_data(res_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Compare every emitted result with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (q_cyc.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected result: got kind=%0d data=%h expected none",
                         res_kind, res_data);
            end else begin
                if (q_cyc[0] != cyc || q_kind[0] != res_kind || q_reg[0] != int'(res_reg)
                    || q_data[0] != res_data) begin
                    failures++;
                    $display("FAIL %s: got cyc=%0d kind=%0d reg=%0d data=%h expected cyc=%0d kind=%0d reg=%0d data=%h",
                             q_tag[0], cyc, res_kind, res_reg, res_data,
                             q_cyc[0], q_kind[0], q_reg[0], q_data[0]);
                end
                void'(q_cyc.pop_front()); void'(q_kind.pop_front()); void'(q_reg.pop_front());
                void'(q_data.pop_front()); void'(q_tag.pop_front());
            end
        end else if (rst_n && q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
            checks++;
            failures++;
            $display("FAIL %s: missing result at cyc=%0d expected data=%h", q_tag[0], cyc, q_data[0]);
            void'(q_cyc.pop_front()); void'(q_kind.pop_front()); void'(q_reg.pop_front());
            void'(q_data.pop_front()); void'(q_tag.pop_front());
        end
        if (cyc > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run hung at cyc=%0d expected completion", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Issue one instruction, check the ready timing, and predict its results.
    task automatic send(input logic [3:0] op, input int d, input int s,
                        input logic [7:0] imm, input logic [63:0] data, input string tag);
        logic [127:0] D, S, N;
        logic [31:0]  dl [4];
        logic [31:0]  sl [4];
        logic [15:0]  w  [4];
        int k, c;
        in_valid = 1'b1; in_op = op; in_dst = 3'(d); in_src = 3'(s);
        in_imm = imm; in_data = data;
        forever begin
            checks++;
            if (in_ready !== (cyc >= busy_until)) begin
                failures++;
                $display("FAIL %s (R2 ready): got in_ready=%b expected %b at cyc=%0d",
                         tag, in_ready, (cyc >= busy_until), cyc);
            end
            if (in_ready) break;
            @(negedge clk);
        end
        c = cyc; k = 0;
        D = mr[d]; S = mr[s]; N = D;
        for (int i = 0; i < 4; i++) begin
            dl[i] = D[32*i +: 32]; sl[i] = S[32*i +: 32]; w[i] = S[16*i +: 16];
        end
        case (op)
            4'd0: begin N[63:0] = data;   push(c, k, 0, d, N[63:0], tag); end
            4'd1: begin N[127:64] = data; push(c, k, 1, d, N[127:64], tag); end
            4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin
                if (op == 4'd2) N = S;
                else if (op == 4'd3) N = D & S;
                else if (op == 4'd4) N = D | S;
                else if (op == 4'd5) N = D ^ S;
                else N = ~D & S;
                push(c, k, 0, d, N[63:0], tag); push(c, k, 1, d, N[127:64], tag);
            end
            4'd7: begin
                N = {sl[1], dl[1], sl[0], dl[0]};
                push(c, k, 1, d, N[127:64], tag); push(c, k, 0, d, N[63:0], tag);
            end
            4'd8: begin
                N = {sl[3], dl[3], sl[2], dl[2]};
                push(c, k, 0, d, N[63:0], tag); push(c, k, 1, d, N[127:64], tag);
            end
            4'd9: begin
                N = {sl[imm[7:6]], sl[imm[5:4]], dl[imm[3:2]], dl[imm[1:0]]};
                push(c, k, 2, d, D[63:0], tag);
                push(c, k, 0, d, N[63:0], tag); push(c, k, 1, d, N[127:64], tag);
            end
            4'd10: begin
                N[63:0] = {w[imm[7:6]], w[imm[5:4]], w[imm[3:2]], w[imm[1:0]]};
                push(c, k, 0, d, N[63:0], tag);
            end
            4'd11: begin
                N[16*imm[2:0] +: 16] = data[15:0];
                if (imm[2]) push(c, k, 1, d, N[127:64], tag);
                else        push(c, k, 0, d, N[63:0], tag);
            end
            default: push(c, k, 3, d, {48'd0, S[16*imm[2:0] +: 16]}, tag);
        endcase
        mr[d] = N;
        busy_until = c + k;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push(input int c, inout int k, input int kind, input int r,
                        input logic [63:0] v, input string tag);
        q_cyc.push_back(c + 1 + k); q_kind.push_back(2'(kind)); q_reg.push_back(r);
        q_data.push_back(v); q_tag.push_back(tag);
        k++;
    endtask

    // Load a full register with a 128-bit value through both load opcodes.
    task automatic load(input int r, input logic [127:0] v);
        send(4'd0, r, r, 8'd0, v[63:0], "R10");
        send(4'd1, r, r, 8'd0, v[127:64], "R10");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mr[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || in_ready !== 1'b1) begin
            failures++;
            $display("FAIL R1 reset state: got res_valid=%b in_ready=%b expected 0 1", res_valid, in_ready);
        end
        send(4'd2, 7, 3, 8'd0, 64'd0, "R1");           // zero readback
        send(4'd9, 6, 5, 8'h1B, 64'd0, "R1");          // shuffle of zeros
        load(0, 128'h00000003_00000002_00000001_00000000);
        load(1, 128'h13131313_12121212_11111111_10101010);
        load(2, 128'hDDDD_CCCC_BBBB_AAAA_9999_8888_7777_6666);
        send(4'd1, 2, 2, 8'd0, 64'h0123_4567_89AB_CDEF, "R10");
        send(4'd2, 7, 2, 8'd0, 64'd0, "R10");
        // Four-lane shuffle with several immediates.
        send(4'd9, 0, 1, 8'hE4, 64'd0, "R3");
        send(4'd9, 0, 1, 8'h1B, 64'd0, "R3");
        send(4'd9, 0, 1, 8'h00, 64'd0, "R2");
        send(4'd9, 0, 1, 8'hFF, 64'd0, "R3");
        load(3, 128'h44444444_33333333_22222222_11111111);
        send(4'd9, 3, 3, 8'h4E, 64'd0, "R3");          // src == dst
        send(4'd9, 3, 3, 8'h1B, 64'd0, "R3");
        // Interleaves.
        load(4, 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0);
        send(4'd7, 4, 1, 8'd0, 64'd0, "R4");
        load(4, 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0);
        send(4'd8, 4, 1, 8'd0, 64'd0, "R4");
        send(4'd7, 1, 1, 8'd0, 64'd0, "R4");
        send(4'd8, 2, 2, 8'd0, 64'd0, "R4");
        // Move and logical.
        send(4'd2, 5, 2, 8'd0, 64'd0, "R5");
        send(4'd3, 5, 4, 8'd0, 64'd0, "R5");
        send(4'd4, 5, 1, 8'd0, 64'd0, "R5");
        send(4'd5, 5, 2, 8'd0, 64'd0, "R5");
        send(4'd6, 5, 0, 8'd0, 64'd0, "R5");
        // Word insert, extract, word shuffle.
        send(4'd11, 6, 6, 8'd1, 64'hFFFF_FFFF_FFFF_BEEF, "R6");
        send(4'd11, 6, 6, 8'd6, 64'h0000_0000_0000_CAFE, "R6");
        send(4'd2, 7, 6, 8'd0, 64'd0, "R6");
        for (int j = 0; j < 8; j += 3) send(4'd12, 7, 2, 8'(j), 64'd0, "R7");
        send(4'd12, 7, 2, 8'd7, 64'd0, "R7");
        send(4'd2, 0, 2, 8'd0, 64'd0, "R7");           // source unchanged
        send(4'd10, 1, 2, 8'h1B, 64'd0, "R8");
        send(4'd10, 1, 2, 8'hA5, 64'd0, "R8");
        send(4'd2, 7, 1, 8'd0, 64'd0, "R8");           // high half kept
        // Back-to-back single-micro-op instructions.
        for (int j = 0; j < 6; j++) send(4'(j % 2), 6, 6, 8'd0, 64'(j) * 64'h1111_0000_2222_0003, "R9");
        send(4'd2, 7, 6, 8'd0, 64'd0, "R9");
        repeat (6) @(negedge clk);
        checks++;
        if (q_cyc.size() != 0) begin
            failures++;
            $display("FAIL R9 drain: got %0d pending results expected 0", q_cyc.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule